// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Edge/Level Controller

This block turns eight already-selected, already-synchronized input pins into eight interrupt request lines. Each channel is set up through a small word-addressed register port: a mode bit picks edge detection or level detection, and two enable registers choose what the channel responds to. The first enable register gates rising edges in edge mode and gates the whole interrupt in level mode. The second enable register gates falling edges in edge mode and selects the active polarity in level mode.

In edge mode, a qualifying transition is latched into a rise or fall status register. The request stays high until software clears the latched bits by writing ones to them. In level mode, nothing is latched and the request follows the pin whenever the pin matches the selected polarity. Both enable registers also have write-one-to-set and write-one-to-clear alias addresses. These let software change single channels without a read-modify-write sequence. Changing a channel's mode discards whatever that channel had latched.

Top module: `pint_ctrl`

## Requirements
- R1: After reset, the mode, first enable, second enable, rise status and fall status registers all read 0, and every request output is 0.
- R2: Writing to the first-enable set alias (word 2) sets each bit written as 1, and writing to its clear alias (word 3) clears each bit written as 1. Bits written as 0 are unchanged, both aliases read as 0, and the register reads back at word 1.
- R3: The second enable register can be written directly at word 4. Its set alias (word 5) and clear alias (word 6) change only the bits written as 1, and both aliases read as 0.
- R4: Data bits 31:8 read as 0 in every register, and writes to them are ignored. Unmapped words 9 to 15 read as 0.
- R5: In edge mode (mode bit n = 0, mode register at word 0), if first-enable bit n is 1, a pin moving 0→1 sets rise status bit n (word 7) at the first clock edge that samples the pin high. irq_o[n] is high from that edge onward.
- R6: In edge mode, if second-enable bit n is 1, a pin moving 1→0 sets fall status bit n (word 8) at the first clock edge that samples the pin low, and irq_o[n] rises with it.
- R7: An edge whose enable bit is 0 latches nothing and raises no request.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new edge and a clear of the same bit arrive in the same cycle, the bit stays set. An edge-mode request falls once both of its status bits are 0.
- R9: In level mode (mode bit n = 1), irq_o[n] is 1 exactly while first-enable bit n is 1 and the pin equals second-enable bit n (1 = active HIGH, 0 = active LOW). It follows the pin without a clock delay and latches no status.
- R10: A write that changes mode bit n clears both status bits of channel n at that clock edge.
- R11: Bit n of every register affects only channel n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Synchronized pin levels, one per channel |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq_o | output | 8 | Per-channel interrupt request |

## Verification
The timing differs by kind of result. A register write is visible on rdata at the first clock edge after the write strobe is sampled. Because rdata is combinational in addr, a read is valid shortly after addr settles. An edge-mode request and its status bit appear at the first clock edge that samples the new pin level. A level-mode request follows the pin within the same cycle. The bench drives on falling edges and samples one nanosecond later, or just before the next falling edge. It first checks that the request is still low before the sampling edge and then checks that it is high after that edge, so an extra or missing register stage shows up as a failure.

// File: rtl/pint_pkg.sv
// Shared constants and the register word map of the pin interrupt controller.
// Assumes a word-addressed register port at least four address bits wide.
package pint_pkg;

    // Register word indices; decoded against the low address bits.
    typedef enum logic [3:0] {
        REG_MODE    = 4'd0,
        REG_EN1     = 4'd1,
        REG_EN1_SET = 4'd2,
        REG_EN1_CLR = 4'd3,
        REG_EN2     = 4'd4,
        REG_EN2_SET = 4'd5,
        REG_EN2_CLR = 4'd6,
        REG_RISE    = 4'd7,
        REG_FALL    = 4'd8
    } reg_sel_e;

    localparam int unsigned SEL_W = 4;

endpackage

// File: rtl/pint_regs.sv
// Register file: mode, two enable registers with set/clear aliases, write-one-
// to-clear strobes for the edge status, and the combinational read mux.
// Assumes NCH <= DW and AW >= 4; upper data bits are dropped on write.
module pint_regs
    import pint_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 4,
    parameter int unsigned DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] rise_st,
    input  logic [NCH-1:0] fall_st,
    output logic [NCH-1:0] mode_q,
    output logic [NCH-1:0] en1_q,
    output logic [NCH-1:0] en2_q,
    output logic [NCH-1:0] mode_chg,
    output logic [NCH-1:0] rise_w1c,
    output logic [NCH-1:0] fall_w1c,
    output logic [DW-1:0]  rdata
);

    localparam int unsigned PAD = DW - NCH;

    logic [NCH-1:0] wbits;
    logic [NCH-1:0] rd_vec;
    logic           hit_mode, hit_en1, hit_en1_set, hit_en1_clr;
    logic           hit_en2, hit_en2_set, hit_en2_clr, hit_rise, hit_fall;

    assign wbits = wdata[NCH-1:0];

    // Decode which register a write strobe targets.
    always_comb begin
        hit_mode    = wr_en && (addr == AW'(REG_MODE));
        hit_en1     = wr_en && (addr == AW'(REG_EN1));
        hit_en1_set = wr_en && (addr == AW'(REG_EN1_SET));
        hit_en1_clr = wr_en && (addr == AW'(REG_EN1_CLR));
        hit_en2     = wr_en && (addr == AW'(REG_EN2));
        hit_en2_set = wr_en && (addr == AW'(REG_EN2_SET));
        hit_en2_clr = wr_en && (addr == AW'(REG_EN2_CLR));
        hit_rise    = wr_en && (addr == AW'(REG_RISE));
        hit_fall    = wr_en && (addr == AW'(REG_FALL));
    end

    // Mode register: plain read/write, resets to all-edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= '0;
        else if (hit_mode) mode_q <= wbits;
    end

    // First enable: direct write plus write-one set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)           en1_q <= '0;
        else if (hit_en1)     en1_q <= wbits;
        else if (hit_en1_set) en1_q <= en1_q | wbits;
        else if (hit_en1_clr) en1_q <= en1_q & ~wbits;
    end

    // Second enable: falling-edge enable or level polarity, same alias scheme.
    always_ff @(posedge clk) begin
        if (!rst_n)           en2_q <= '0;
        else if (hit_en2)     en2_q <= wbits;
        else if (hit_en2_set) en2_q <= en2_q | wbits;
        else if (hit_en2_clr) en2_q <= en2_q & ~wbits;
    end

    // Strobes toward the channels: mode flips and status clears.
    always_comb begin
        mode_chg = hit_mode ? (wbits ^ mode_q) : '0;
        rise_w1c = hit_rise ? wbits : '0;
        fall_w1c = hit_fall ? wbits : '0;
    end

    // Read mux: aliases and unmapped words read as zero.
    always_comb begin
        case (addr)
            AW'(REG_MODE): rd_vec = mode_q;
            AW'(REG_EN1):  rd_vec = en1_q;
            AW'(REG_EN2):  rd_vec = en2_q;
            AW'(REG_RISE): rd_vec = rise_st;
            AW'(REG_FALL): rd_vec = fall_st;
            default:       rd_vec = '0;
        endcase
    end

    generate
        if (PAD > 0) begin : g_pad
            assign rdata = {{PAD{1'b0}}, rd_vec};
        end else begin : g_nopad
            assign rdata = rd_vec;
        end
    endgenerate

endmodule

// File: rtl/pint_chan.sv
// One pin interrupt channel: edge detect against the previous sample, latched
// rise/fall status with write-one-to-clear, and the level/edge request select.
// Assumes pin_i is already synchronized to clk.
module pint_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic mode,
    input  logic en1,
    input  logic en2,
    input  logic mode_chg,
    input  logic rise_clr,
    input  logic fall_clr,
    output logic rise_st,
    output logic fall_st,
    output logic irq
);

    logic pin_q;
    logic rise_hit;
    logic fall_hit;

    // Previous pin sample; also loads during reset so no false edge follows it.
    always_ff @(posedge clk) begin
        pin_q <= pin_i;
    end

    // Qualified edges, only meaningful in edge mode.
    always_comb begin
        rise_hit = !mode && en1 &&  pin_i && !pin_q;
        fall_hit = !mode && en2 && !pin_i &&  pin_q;
    end

    // Rise status: a mode flip wipes it, a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        rise_st <= 1'b0;
        else if (mode_chg) rise_st <= 1'b0;
        else if (rise_hit) rise_st <= 1'b1;
        else if (rise_clr) rise_st <= 1'b0;
    end

    // Fall status: same priority order as rise status.
    always_ff @(posedge clk) begin
        if (!rst_n)        fall_st <= 1'b0;
        else if (mode_chg) fall_st <= 1'b0;
        else if (fall_hit) fall_st <= 1'b1;
        else if (fall_clr) fall_st <= 1'b0;
    end

    // Request: live level match in level mode, latched status in edge mode.
    always_comb begin
        if (mode) irq = en1 && (pin_i == en2);
        else      irq = rise_st || fall_st;
    end

endmodule

// File: rtl/pint_ctrl.sv
// Top of the pin interrupt controller: one register file and NCH channels.
// Assumes pins are synchronized and one register access per cycle.
module pint_ctrl #(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 4,
    parameter int unsigned DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_i,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] irq_o
);

    logic [NCH-1:0] mode_q, en1_q, en2_q;
    logic [NCH-1:0] mode_chg, rise_w1c, fall_w1c;
    logic [NCH-1:0] rise_st, fall_st;

    pint_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rise_st  (rise_st),
        .fall_st  (fall_st),
        .mode_q   (mode_q),
        .en1_q    (en1_q),
        .en2_q    (en2_q),
        .mode_chg (mode_chg),
        .rise_w1c (rise_w1c),
        .fall_w1c (fall_w1c),
        .rdata    (rdata)
    );

    // One detector per channel; bit n of every register drives channel n.
    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            pint_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_i    (pin_i[n]),
                .mode     (mode_q[n]),
                .en1      (en1_q[n]),
                .en2      (en2_q[n]),
                .mode_chg (mode_chg[n]),
                .rise_clr (rise_w1c[n]),
                .fall_clr (fall_w1c[n]),
                .rise_st  (rise_st[n]),
                .fall_st  (fall_st[n]),
                .irq      (irq_o[n])
            );
        end
    endgenerate

endmodule

// File: rtl/pint_ctrl_chk.sv
// Assertion checker for pint_ctrl, bound into every instance of the top.
// Keeps its own copy of the previous pin sample.
module pint_ctrl_chk #(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 4,
    parameter int unsigned DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] pin_i,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  rdata,
    input logic [NCH-1:0] irq_o,
    input logic [NCH-1:0] mode_q,
    input logic [NCH-1:0] en1_q,
    input logic [NCH-1:0] en2_q,
    input logic [NCH-1:0] mode_chg,
    input logic [NCH-1:0] rise_st,
    input logic [NCH-1:0] fall_st
);

    logic [NCH-1:0] pin_prev;
    logic [NCH-1:0] rmask, fmask;

    // Independent previous-sample copy for edge expectations.
    always_ff @(posedge clk) begin
        pin_prev <= pin_i;
    end

    assign rmask = ~mode_q & en1_q &  pin_i & ~pin_prev & ~mode_chg;
    assign fmask = ~mode_q & en2_q & ~pin_i &  pin_prev & ~mode_chg;

    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rmask != '0) |=> ((rise_st & $past(rmask)) == $past(rmask))); // R5
    AST_FALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fmask != '0) |=> ((fall_st & $past(fmask)) == $past(fmask))); // R6
    AST_MODE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg != '0) |=> (((rise_st | fall_st) & $past(mode_chg)) == '0)); // R10
    AST_LEVEL_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (((rise_st | fall_st) & mode_q) == '0)); // R9
    AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & mode_q) == (mode_q & en1_q & ~(pin_i ^ en2_q)))); // R9
    AST_EDGE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~mode_q) == ((rise_st | fall_st) & ~mode_q))); // R8
    AST_ALIAS_READ0: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(2) || addr == AW'(3) || addr == AW'(5) || addr == AW'(6))
        |-> (rdata == '0)); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[DW-1:NCH] == '0)); // R4

endmodule

bind pint_ctrl pint_ctrl_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .addr     (addr),
    .rdata    (rdata),
    .irq_o    (irq_o),
    .mode_q   (mode_q),
    .en1_q    (en1_q),
    .en2_q    (en2_q),
    .mode_chg (mode_chg),
    .rise_st  (rise_st),
    .fall_st  (fall_st)
);

// File: tb/pint_ctrl_tb.sv
// Directed bench for pint_ctrl: one task per scenario, each checking itself.
module pint_ctrl_tb;

    localparam int unsigned NCH = 8;
    localparam int unsigned AW  = 4;
    localparam int unsigned DW  = 32;

    localparam logic [AW-1:0] A_MODE = 4'd0, A_EN1 = 4'd1, A_EN1S = 4'd2,
        A_EN1C = 4'd3, A_EN2 = 4'd4, A_EN2S = 4'd5, A_EN2C = 4'd6,
        A_RISE = 4'd7, A_FALL = 4'd8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin_i = '0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  wdata = '0;
    logic [DW-1:0]  rdata;
    logic [NCH-1:0] irq_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pint_ctrl #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a,
                          input logic [DW-1:0] exp);
        addr = a;
        #1;
        chk(req, $sformatf("read word %0d", a), rdata, exp);
    endtask

    // Change pins at a falling edge; returns one ns later, before the next rise.
    task automatic pins(input logic [NCH-1:0] v);
        @(negedge clk);
        pin_i = v;
        #1;
    endtask

    task automatic t_reset();
        rd_chk("R1", A_MODE, 0); rd_chk("R1", A_EN1, 0); rd_chk("R1", A_EN2, 0);
        rd_chk("R1", A_RISE, 0); rd_chk("R1", A_FALL, 0);
        chk("R1", "irq after reset", DW'(irq_o), 0);
    endtask

    task automatic t_en1_alias();
        wr(A_EN1S, 32'h0F); rd_chk("R2", A_EN1, 32'h0F);
        wr(A_EN1C, 32'h05); rd_chk("R2", A_EN1, 32'h0A);
        wr(A_EN1S, 32'h00); rd_chk("R2", A_EN1, 32'h0A);
        rd_chk("R2", A_EN1S, 0); rd_chk("R2", A_EN1C, 0);
        wr(A_EN1, 32'h00);
    endtask

    task automatic t_en2_alias();
        wr(A_EN2, 32'h30);  rd_chk("R3", A_EN2, 32'h30);
        wr(A_EN2S, 32'h81); rd_chk("R3", A_EN2, 32'hB1);
        wr(A_EN2C, 32'h10); rd_chk("R3", A_EN2, 32'hA1);
        rd_chk("R3", A_EN2S, 0); rd_chk("R3", A_EN2C, 0);
        wr(A_EN2, 32'h00);
    endtask

    task automatic t_reserved();
        wr(A_EN1, 32'hFFFF_FF03); rd_chk("R4", A_EN1, 32'h03);
        wr(A_EN1, 32'h00);
        for (int a = 9; a < 16; a++) rd_chk("R4", AW'(a), 0);
    endtask

    task automatic t_rise();
        wr(A_EN1, 32'h01);
        pins(8'h01);
        chk("R5", "irq before sampling edge", DW'(irq_o), 0);
        @(negedge clk); #1;
        chk("R5", "irq after rise", DW'(irq_o), 32'h01);
        rd_chk("R5", A_RISE, 32'h01);
        pins(8'h00); @(negedge clk); #1;
        rd_chk("R7", A_FALL, 0);
        wr(A_RISE, 32'h00); rd_chk("R8", A_RISE, 32'h01);
        wr(A_RISE, 32'h01); rd_chk("R8", A_RISE, 0);
        chk("R8", "irq after clear", DW'(irq_o), 0);
        wr(A_EN1, 32'h00);
    endtask

    task automatic t_fall();
        wr(A_EN2, 32'h04);
        pins(8'h04); @(negedge clk); #1;
        rd_chk("R7", A_RISE, 0);
        chk("R7", "irq on disabled rise", DW'(irq_o), 0);
        pins(8'h00);
        chk("R6", "irq before sampling edge", DW'(irq_o), 0);
        @(negedge clk); #1;
        chk("R6", "irq after fall", DW'(irq_o), 32'h04);
        rd_chk("R6", A_FALL, 32'h04);
        wr(A_FALL, 32'h04); rd_chk("R8", A_FALL, 0);
        wr(A_EN2, 32'h00);
    endtask

    task automatic t_priority();
        wr(A_EN1, 32'h02);
        @(negedge clk);
        pin_i = 8'h02; wr_en = 1'b1; addr = A_RISE; wdata = 32'h02;
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R8", A_RISE, 32'h02);
        wr(A_RISE, 32'h02); pins(8'h00);
        wr(A_EN1, 32'h00);
    endtask

    task automatic t_level();
        wr(A_MODE, 32'h10); wr(A_EN1, 32'h10); wr(A_EN2, 32'h10);
        pins(8'h10);
        chk("R9", "active-high, pin high", DW'(irq_o), 32'h10);
        pins(8'h00);
        chk("R9", "active-high, pin low", DW'(irq_o), 0);
        wr(A_EN2C, 32'h10); #1;
        chk("R9", "active-low, pin low", DW'(irq_o), 32'h10);
        rd_chk("R9", A_RISE, 0); rd_chk("R9", A_FALL, 0);
        wr(A_EN1C, 32'h10); #1;
        chk("R9", "level disabled", DW'(irq_o), 0);
        wr(A_MODE, 32'h00);
    endtask

    task automatic t_mode_change();
        wr(A_EN1, 32'h28);
        pins(8'h28); @(negedge clk); #1;
        rd_chk("R11", A_RISE, 32'h28);
        wr(A_MODE, 32'h08);
        rd_chk("R10", A_RISE, 32'h20);
        chk("R11", "other channel still requests", DW'(irq_o), 32'h20);
        wr(A_RISE, 32'h20); wr(A_MODE, 32'h00); wr(A_EN1, 32'h00);
        pins(8'h00);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_en1_alias();
        t_en2_alias();
        t_reserved();
        t_rise();
        t_fall();
        t_priority();
        t_level();
        t_mode_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule